// File: doc/BRIEF.md
# Carry-Select Add/Subtract Unit

A purely combinational arithmetic unit for a small register machine. Each evaluation takes an operation code, a two-bit carry-selection code, the machine's current carry flag and two register values: a source `S` and a destination `D`. It produces the value to be written back into the destination register, a write strobe and the next value of the carry flag. Register storage, flag storage and instruction sequencing belong to the surrounding machine.

The carry-in is chosen per operation by the selection code. It can be a constant zero, a constant one, the stored flag or the inverse of the stored flag. This one mechanism gives plain and chained addition, increment, and subtraction with or without borrow. One operation passes the source plus carry-in through and ignores `D`. Operation code 3 is not an arithmetic operation: the unit requests no write and hands the flag back unchanged.

Top module: `carrySelAlu`

## Requirements
- R1: The carry-in is set by `ccSel`: 00 gives 0, 01 gives 1, 10 gives `carryFlag`, and 11 gives the inverse of `carryFlag`.
- R2: With `opCode` 00, `result` is (S + carry-in) mod 2^W and `carryNext` is bit W of that sum. The value of `dstVal` has no effect on either output.
- R3: With `opCode` 01, `result` is (S + D + carry-in) mod 2^W and `carryNext` is bit W of the sum.
- R4: With `opCode` 10, the unit computes D + (~S mod 2^W) + carry-in. `result` is the low W bits and `carryNext` is bit W, so `carryNext` is 1 exactly when no borrow occurred. With carry-in 1 this is D − S, with carry 1 when D ≥ S.
- R5: For `opCode` values 00, 01 and 10, `writeEn` is 1.
- R6: For `opCode` 11, `writeEn` is 0, `carryNext` equals `carryFlag` and `result` equals `dstVal`.
- R7: The data width W is the parameter `DataWidth` (default 4), and the carry out is always the bit just above the most significant result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 2 | Operation: 00 source plus carry, 01 add, 10 subtract, 11 no write |
| ccSel | input | 2 | Carry-in selection code |
| carryFlag | input | 1 | Current stored carry flag |
| srcVal | input | DataWidth | Source register value S |
| dstVal | input | DataWidth | Destination register value D |
| result | output | DataWidth | Value to write into the destination register |
| writeEn | output | 1 | High when the destination and the flag should be written |
| carryNext | output | 1 | Next value of the carry flag |

## Verification
The bench builds two copies of the unit: one at the default width of 4 and one at width 2. At both widths every combination of operation, selection code, flag and operand pair is small enough to cover exhaustively. The wrap-around sums, the borrow edges where D equals S, and the all-ones operands are therefore all reached. The narrow copy shows that the carry position follows the width parameter and is not fixed at bit 4.

// File: rtl/carry_sel_alu_pkg.sv
package carry_sel_alu_pkg;
  typedef enum logic [1:0] {
    OP_SRC_CARRY = 2'b00,
    OP_ADD       = 2'b01,
    OP_SUB       = 2'b10,
    OP_NONE      = 2'b11
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'b00,
    CIN_ONE   = 2'b01,
    CIN_FLAG  = 2'b10,
    CIN_NFLAG = 2'b11
  } cinSel_e;

  typedef struct packed {
    logic useDst;   // feed D into the adder's first input
    logic invSrc;   // one's complement of S on the second input
    logic carryIn;  // selected carry-in
    logic wrEn;     // write back result and flag
  } aluStrobe_t;
endpackage

// File: rtl/carry_sel_alu_ctrl.sv
module carry_sel_alu_ctrl
  import carry_sel_alu_pkg::*;
(
  input  logic [1:0] opCode,
  input  logic [1:0] ccSel,
  input  logic       carryFlag,
  output aluStrobe_t strobe
);
  aluOp_e  opDec;
  cinSel_e cinDec;

  assign opDec  = aluOp_e'(opCode);
  assign cinDec = cinSel_e'(ccSel);

  always_comb begin
    strobe = '0;
    unique case (cinDec)
      CIN_ZERO:  strobe.carryIn = 1'b0;
      CIN_ONE:   strobe.carryIn = 1'b1;
      CIN_FLAG:  strobe.carryIn = carryFlag;
      CIN_NFLAG: strobe.carryIn = ~carryFlag;
      default:   strobe.carryIn = 1'b0;
    endcase
    unique case (opDec)
      OP_SRC_CARRY: strobe.wrEn = 1'b1;
      OP_ADD:       begin strobe.wrEn = 1'b1; strobe.useDst = 1'b1; end
      OP_SUB:       begin strobe.wrEn = 1'b1; strobe.useDst = 1'b1; strobe.invSrc = 1'b1; end
      OP_NONE:      strobe.wrEn = 1'b0;
      default:      strobe.wrEn = 1'b0;
    endcase
  end

  // R1: a constant selection never depends on the flag
  always_comb begin
    p_const_cin_r1: assert (!(ccSel == 2'b00) || strobe.carryIn == 1'b0);
    p_one_cin_r1:   assert (!(ccSel == 2'b01) || strobe.carryIn == 1'b1);
  end
endmodule

// File: rtl/carry_sel_alu_dp.sv
module carry_sel_alu_dp
  import carry_sel_alu_pkg::*;
#(
  parameter int DataWidth = 4
) (
  input  aluStrobe_t           strobe,
  input  logic                 carryFlag,
  input  logic [DataWidth-1:0] srcVal,
  input  logic [DataWidth-1:0] dstVal,
  output logic [DataWidth-1:0] result,
  output logic                 carryNext
);
  localparam int SumWidth = DataWidth + 1;

  logic [DataWidth-1:0] opA;
  logic [DataWidth-1:0] opB;
  logic [SumWidth-1:0]  sumFull;

  assign opA     = strobe.useDst ? dstVal : '0;
  assign opB     = strobe.invSrc ? ~srcVal : srcVal;
  assign sumFull = {1'b0, opA} + {1'b0, opB} + {{DataWidth{1'b0}}, strobe.carryIn};

  assign result    = strobe.wrEn ? sumFull[DataWidth-1:0] : dstVal;
  assign carryNext = strobe.wrEn ? sumFull[DataWidth] : carryFlag;
endmodule

// File: rtl/carrySelAlu.sv
module carrySelAlu
  import carry_sel_alu_pkg::*;
#(
  parameter int DataWidth = 4
) (
  input  logic [1:0]           opCode,
  input  logic [1:0]           ccSel,
  input  logic                 carryFlag,
  input  logic [DataWidth-1:0] srcVal,
  input  logic [DataWidth-1:0] dstVal,
  output logic [DataWidth-1:0] result,
  output logic                 writeEn,
  output logic                 carryNext
);
  aluStrobe_t strobe;

  carry_sel_alu_ctrl i_ctrl (
    .opCode    (opCode),
    .ccSel     (ccSel),
    .carryFlag (carryFlag),
    .strobe    (strobe)
  );

  carry_sel_alu_dp #(.DataWidth(DataWidth)) i_dp (
    .strobe    (strobe),
    .carryFlag (carryFlag),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .result    (result),
    .carryNext (carryNext)
  );

  assign writeEn = strobe.wrEn;

  // Port-level checks relating operands to the datapath outputs
  always_comb begin
    p_src_pass_r2: assert (!(opCode == 2'b00 && ccSel == 2'b00) ||
                           (result == srcVal && carryNext == 1'b0));
    p_plain_add_r3: assert (!(opCode == 2'b01 && ccSel == 2'b00) ||
                            ({carryNext, result} == ({1'b0, srcVal} + {1'b0, dstVal})));
    p_flag_add_r1: assert (!(opCode == 2'b01 && ccSel == 2'b10) ||
                           ({carryNext, result} == ({1'b0, srcVal} + {1'b0, dstVal} +
                                                    {{DataWidth{1'b0}}, carryFlag})));
    p_sub_borrow_r4: assert (!(opCode == 2'b10 && ccSel == 2'b01) ||
                             (result == DataWidth'(dstVal - srcVal) &&
                              carryNext == (dstVal >= srcVal)));
    p_write_r5: assert (opCode == 2'b11 || writeEn);
    p_no_write_r6: assert (opCode != 2'b11 ||
                           (!writeEn && carryNext == carryFlag && result == dstVal));
  end
endmodule

// File: tb/test_carrySelAlu.sv
module test_carrySelAlu;
  localparam int WideW   = 4;
  localparam int NarrowW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0] opCode = '0;
  logic [1:0] ccSel = '0;
  logic carryFlag = 1'b0;
  logic [WideW-1:0] srcW = '0, dstW = '0, resW;
  logic [NarrowW-1:0] srcN = '0, dstN = '0, resN;
  logic weW, cW, weN, cN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  carrySelAlu #(.DataWidth(WideW)) i_carrySelAlu (
    .opCode(opCode), .ccSel(ccSel), .carryFlag(carryFlag),
    .srcVal(srcW), .dstVal(dstW), .result(resW), .writeEn(weW), .carryNext(cW));

  carrySelAlu #(.DataWidth(NarrowW)) i_carrySelAlu_narrow (
    .opCode(opCode), .ccSel(ccSel), .carryFlag(carryFlag),
    .srcVal(srcN), .dstVal(dstN), .result(resN), .writeEn(weN), .carryNext(cN));

  // Behavioural reference built from the requirement text
  function automatic void refModel(input int w, input int op, input int cc, input int cf,
                                   input int s, input int d,
                                   output int r, output int c, output int we);
    int ci, mask, t;
    mask = (1 << w) - 1;
    case (cc)
      0: ci = 0;
      1: ci = 1;
      2: ci = cf;
      default: ci = 1 - cf;
    endcase
    we = 1;
    case (op)
      0: t = s + ci;
      1: t = s + d + ci;
      2: t = d + ((~s) & mask) + ci;
      default: t = 0;
    endcase
    if (op == 3) begin
      we = 0; r = d; c = cf;
    end else begin
      r = t & mask; c = (t >> w) & 1;
    end
  endfunction

  function automatic string tagFor(input int op);
    case (op)
      0: return "R2/R1/R5";
      1: return "R3/R1/R5";
      2: return "R4/R1/R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input string tag, input int w, input int actR, input int actC,
                         input int actWe, input int expR, input int expC, input int expWe);
    checks++;
    if (actR != expR || actC != expC || actWe != expWe) begin
      failures++;
      $display("FAIL %s W=%0d op=%0d cc=%0d cf=%0d: actual r=%0d c=%0d we=%0d expected r=%0d c=%0d we=%0d",
               tag, w, opCode, ccSel, carryFlag, actR, actC, actWe, expR, expC, expWe);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    int r, c, we;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Idle state: all-zero inputs give source-plus-zero with no carry (R2, R5)
    @(negedge clk);
    compare("R2 idle", WideW, int'(resW), int'(cW), int'(weW), 0, 0, 1);

    for (int op = 0; op < 4; op++)
      for (int cc = 0; cc < 4; cc++)
        for (int cf = 0; cf < 2; cf++)
          for (int s = 0; s < 16; s++)
            for (int d = 0; d < 16; d++) begin
              @(posedge clk);
              #1;
              opCode = op[1:0]; ccSel = cc[1:0]; carryFlag = cf[0];
              srcW = s[WideW-1:0]; dstW = d[WideW-1:0];
              srcN = s[NarrowW-1:0]; dstN = d[NarrowW-1:0];
              @(negedge clk);
              refModel(WideW, op, cc, cf, s, d, r, c, we);
              compare(tagFor(op), WideW, int'(resW), int'(cW), int'(weW), r, c, we);
              if (s < 4 && d < 4) begin
                // R7: carry position follows the width parameter
                refModel(NarrowW, op, cc, cf, s, d, r, c, we);
                compare({tagFor(op), " R7"}, NarrowW, int'(resN), int'(cN), int'(weN), r, c, we);
              end
            end

    // R2: D is ignored by the source-plus-carry operation
    @(posedge clk); #1;
    opCode = 2'b00; ccSel = 2'b01; carryFlag = 1'b0; srcW = 4'd7; dstW = 4'd0;
    @(negedge clk);
    compare("R2 dst-ignored a", WideW, int'(resW), int'(cW), int'(weW), 8, 0, 1);
    @(posedge clk); #1;
    dstW = 4'hF;
    @(negedge clk);
    compare("R2 dst-ignored b", WideW, int'(resW), int'(cW), int'(weW), 8, 0, 1);

    // R4: equal operands with carry-in 1 give zero and no borrow
    @(posedge clk); #1;
    opCode = 2'b10; ccSel = 2'b01; srcW = 4'd9; dstW = 4'd9;
    @(negedge clk);
    compare("R4 equal", WideW, int'(resW), int'(cW), int'(weW), 0, 1, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule